// File: doc/BRIEF.md
# Interprocessor Control Status Register

This block holds one 64-bit control and status word for a chipset that serves four processors. The word carries a pending interprocessor interrupt bit and a pending interval-timer interrupt bit for each processor. It also carries two 4-bit arbitration status fields and a 4-bit read/write field. Each pending bit drives a level output to its processor. A timer block raises the interval-timer bits through per-processor set strobes. Software can only clear those bits.

The bus side is 32 bits wide, so each 64-bit access takes two halves. A low-half write is only parked in a 32-bit staging latch. The following high-half write supplies the upper word and applies the whole 64-bit value, field by field, under mixed write rules. A low-half read returns bits 31:0 and parks bits 63:32 in the same staging latch. In the returned data, bits 1:0 are replaced by the number of the processor doing the read. A high-half read then returns the latch.

Top module: `ipc_misc_csr`

## Requirements
- R1: After reset the register, the staging latch, the read data and all interrupt level outputs are zero.
- R2: A write with `bus_hi`=0 stores `bus_wdata` in the staging latch and changes nothing else. A write with `bus_hi`=1 commits the 64-bit value V = {`bus_wdata`, latch}.
- R3: A read with `bus_hi`=0 returns, on the next cycle, register bits 31:0 with bits 1:0 replaced by `bus_cpu`. It also loads register bits 63:32 into the staging latch. A read with `bus_hi`=1 returns the staging latch. The latch is shared between reads and writes.
- R4: A commit clears every register bit where V has a 1 under mask 0x1000_0FF0, that is bits 11:4 and bit 28.
- R5: A commit ORs V bits 15:12 into register bits 11:8. In the same commit, this set wins over a clear of the same bit from R4.
- R6: When V bit 20 is 1, a commit clears register bits 23:16 and makes none of the set updates of R7.
- R7: When V bit 20 is 0, V bits 23:20 are ORed into register bits 23:20. V bits 19:16 are loaded into register bits 19:16 only if those register bits are all zero beforehand; otherwise bits 19:16 keep their value.
- R8: A commit loads register bits 43:40 from V bits 43:40. Every other register bit not named in R4 to R7 always reads as zero.
- R9: `ipi_lvl[i]` equals register bit 8+i and changes only in the cycle after a commit.
- R10: `iti_lvl[i]` equals register bit 4+i. `tick_set[i]` sets that bit on the next cycle and wins over a clear committed in the same cycle. A write can clear the bit but never set it.
- R11: When `bus_wr` and `bus_rd` are both asserted, only the write is performed and `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one 32-bit half |
| bus_rd | input | 1 | Read strobe for one 32-bit half |
| bus_hi | input | 1 | Half select: 0 low word, 1 high word |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 2 | Number of the requesting processor |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tick_set | input | 4 | Per-processor interval-timer set strobes |
| ipi_lvl | output | 4 | Interprocessor interrupt level per processor |
| iti_lvl | output | 4 | Interval-timer interrupt level per processor |

## Verification
A wrong pending bit is visible on the level outputs one cycle after the commit or strobe that caused it. It can therefore be caught at the next sample. Errors in the arbitration fields, the read/write field or the staging latch show up only through the read path. For that reason reads follow each scenario, and the bench's reference model compares read data every cycle. A latch that is not shared between reads and writes appears at the first high-half read that follows a write.

// File: rtl/ipc_misc_csr.sv
module ipc_misc_csr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_hi,
  input  logic [31:0] bus_wdata,
  input  logic [1:0]  bus_cpu,
  output logic [31:0] bus_rdata,
  input  logic [3:0]  tick_set,
  output logic [3:0]  ipi_lvl,
  output logic [3:0]  iti_lvl
);
  localparam logic [63:0] CLR_MASK = 64'h0000_0000_1000_0FF0;
  localparam logic [63:0] ACL_BIT  = 64'h0000_0000_0010_0000;
  localparam logic [63:0] ABT_MASK = 64'h0000_0000_00F0_0000;
  localparam logic [63:0] ABW_MASK = 64'h0000_0000_000F_0000;
  localparam logic [63:0] REQ_MASK = 64'h0000_0000_0000_F000;
  localparam logic [63:0] RW_MASK  = 64'h0000_0F00_0000_0000;

  logic [63:0] misc_q, misc_d;
  logic [31:0] half_q;
  logic [31:0] rdata_q;

  wire         commit = bus_wr & bus_hi;
  wire [63:0]  wv     = {bus_wdata, half_q};
  wire         abw_empty = ((misc_q & ABW_MASK) == 64'b0);

  always_comb begin
    misc_d = misc_q;
    if (commit) begin
      misc_d = misc_q & ~(wv & CLR_MASK);
      if ((wv & ACL_BIT) != 64'b0) begin
        misc_d = misc_d & ~(ABT_MASK | ABW_MASK);
      end else begin
        misc_d = misc_d | (wv & ABT_MASK);
        if (abw_empty) misc_d = misc_d | (wv & ABW_MASK);
      end
      misc_d = misc_d | ((wv & REQ_MASK) >> 4);
      misc_d = (misc_d & ~RW_MASK) | (wv & RW_MASK);
    end
    misc_d[7:4] = misc_d[7:4] | tick_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc_q  <= '0;
      half_q  <= '0;
      rdata_q <= '0;
    end else begin
      misc_q <= misc_d;
      if (bus_wr) begin
        if (!bus_hi) half_q <= bus_wdata;
      end else if (bus_rd) begin
        if (bus_hi) begin
          rdata_q <= half_q;
        end else begin
          rdata_q <= misc_q[31:0] | {30'b0, bus_cpu};
          half_q  <= misc_q[63:32];
        end
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign ipi_lvl   = misc_q[11:8];
  assign iti_lvl   = misc_q[7:4];
endmodule

// File: rtl/ipc_misc_csr_chk.sv
module ipc_misc_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        bus_hi,
  input logic [1:0]  bus_cpu,
  input logic [31:0] bus_rdata,
  input logic [3:0]  tick_set,
  input logic [3:0]  ipi_lvl,
  input logic [3:0]  iti_lvl,
  input logic        acl_bit,
  input logic [63:0] misc_q
);
  a_r9_ipi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_hi) |=> $stable(ipi_lvl));

  a_r10_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_set != 4'b0) |=> ((iti_lvl & $past(tick_set)) == $past(tick_set)));

  a_r10_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((iti_lvl & ~$past(iti_lvl) & ~$past(tick_set)) == 4'b0));

  a_r3_cpu_id: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !bus_hi) |=> (bus_rdata[1:0] == $past(bus_cpu)));

  a_r6_acl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_hi && acl_bit) |=> (misc_q[23:16] == 8'b0));

  a_r11_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd) |=> $stable(bus_rdata));

  a_r2_low_write_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_hi && tick_set == 4'b0) |=> $stable(misc_q));
endmodule

bind ipc_misc_csr ipc_misc_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_hi(bus_hi),
  .bus_cpu(bus_cpu), .bus_rdata(bus_rdata), .tick_set(tick_set),
  .ipi_lvl(ipi_lvl), .iti_lvl(iti_lvl), .acl_bit(half_q[20]), .misc_q(misc_q)
);

// File: tb/ipc_misc_csr_bench.sv
module ipc_misc_csr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_hi = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_cpu = '0;
  logic [3:0]  tick_set = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  ipi_lvl, iti_lvl;

  integer checks = 0, failures = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  ipc_misc_csr u_ipc_misc_csr (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_hi(bus_hi),
    .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
    .tick_set(tick_set), .ipi_lvl(ipi_lvl), .iti_lvl(iti_lvl)
  );

  logic [63:0] m_reg, m_nxt, m_v;
  logic [31:0] m_latch, m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = '0; m_latch = '0; m_rdata = '0;
    end else begin
      m_nxt = m_reg;
      if (bus_wr && bus_hi) begin
        m_v = {bus_wdata, m_latch};
        for (int b = 4; b < 12; b++) if (m_v[b]) m_nxt[b] = 1'b0;
        if (m_v[28]) m_nxt[28] = 1'b0;
        if (m_v[20]) begin
          m_nxt[23:16] = 8'h00;
        end else begin
          for (int b = 20; b < 24; b++) if (m_v[b]) m_nxt[b] = 1'b1;
          if (m_reg[19:16] == 4'h0) m_nxt[19:16] = m_v[19:16];
        end
        for (int k = 0; k < 4; k++) if (m_v[12+k]) m_nxt[8+k] = 1'b1;
        m_nxt[43:40] = m_v[43:40];
      end
      for (int k = 0; k < 4; k++) if (tick_set[k]) m_nxt[4+k] = 1'b1;
      if (bus_wr) begin
        if (!bus_hi) m_latch = bus_wdata;
      end else if (bus_rd) begin
        if (bus_hi) m_rdata = m_latch;
        else begin
          m_rdata = {m_reg[31:2], bus_cpu};
          m_latch = m_reg[63:32];
        end
      end
      m_reg = m_nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks = checks + 3;
      if (ipi_lvl !== m_reg[11:8]) begin
        failures = failures + 1;
        $display("FAIL R9 model ipi_lvl act=%h exp=%h", ipi_lvl, m_reg[11:8]);
      end
      if (iti_lvl !== m_reg[7:4]) begin
        failures = failures + 1;
        $display("FAIL R10 model iti_lvl act=%h exp=%h", iti_lvl, m_reg[7:4]);
      end
      if (bus_rdata !== m_rdata) begin
        failures = failures + 1;
        $display("FAIL R3 model bus_rdata act=%h exp=%h", bus_rdata, m_rdata);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic hi,
                     input logic [31:0] d, input logic [3:0] tk);
    bus_wr = wr; bus_rd = rd; bus_hi = hi; bus_wdata = d; tick_set = tk;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_hi = 1'b0; bus_wdata = '0; tick_set = '0;
  endtask

  task automatic wr64(input logic [31:0] hi_w, input logic [31:0] lo_w);
    cyc(1'b1, 1'b0, 1'b0, lo_w, 4'h0);
    cyc(1'b1, 1'b0, 1'b1, hi_w, 4'h0);
  endtask

  task automatic rd_lo; cyc(1'b0, 1'b1, 1'b0, 32'h0, 4'h0); endtask
  task automatic rd_hi; cyc(1'b0, 1'b1, 1'b1, 32'h0, 4'h0); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures = failures + 1;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bus_cpu = 2'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ipi after reset", {28'b0, ipi_lvl}, 32'h0);
    chk("R1 iti after reset", {28'b0, iti_lvl}, 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    rd_lo; chk("R1 low read", bus_rdata, 32'h2);
    rd_hi; chk("R1 high read", bus_rdata, 32'h0);

    cyc(1'b1, 1'b0, 1'b0, 32'h0000_F000, 4'h0);
    chk("R2 low write parks", {28'b0, ipi_lvl}, 32'h0);
    cyc(1'b1, 1'b0, 1'b1, 32'h0, 4'h0);
    chk("R2 R5 commit sets ipi", {28'b0, ipi_lvl}, 32'hF);

    wr64(32'h0, 32'h0000_0500);
    chk("R4 clear ipi bits", {28'b0, ipi_lvl}, 32'hA);
    wr64(32'h0, 32'h0000_2200);
    chk("R5 set beats clear", {28'b0, ipi_lvl}, 32'hA);

    cyc(1'b0, 1'b0, 1'b0, 32'h0, 4'b0101);
    chk("R10 tick sets iti", {28'b0, iti_lvl}, 32'h5);
    wr64(32'h0, 32'h0000_0010);
    chk("R10 sw clears iti", {28'b0, iti_lvl}, 32'h4);
    cyc(1'b1, 1'b0, 1'b0, 32'h0000_0040, 4'h0);
    cyc(1'b1, 1'b0, 1'b1, 32'h0, 4'b0100);
    chk("R10 tick beats clear", {28'b0, iti_lvl}, 32'h4);
    wr64(32'h0, 32'h0000_0FF0);
    chk("R4 clear all iti", {28'b0, iti_lvl}, 32'h0);
    chk("R4 clear all ipi", {28'b0, ipi_lvl}, 32'h0);

    wr64(32'h0, 32'h00E3_0000);
    rd_lo; chk("R7 abt abw set", bus_rdata, 32'h00E3_0002);
    wr64(32'h0, 32'h0005_0000);
    rd_lo; chk("R7 abw held when nonzero", bus_rdata, 32'h00E3_0002);
    wr64(32'h0, 32'h00F1_0000);
    rd_lo; chk("R6 acl clears fields", bus_rdata, 32'h0000_0002);

    wr64(32'hFFFF_FFFF, 32'h0);
    bus_cpu = 2'd3;
    rd_lo; chk("R8 low word", bus_rdata, 32'h0000_0003);
    rd_hi; chk("R8 rw field only", bus_rdata, 32'h0000_0F00);

    cyc(1'b1, 1'b0, 1'b0, 32'h1234_5678, 4'h0);
    rd_hi; chk("R3 shared latch after write", bus_rdata, 32'h1234_5678);
    bus_cpu = 2'd1;
    rd_lo; chk("R3 low read cpu id", bus_rdata, 32'h0000_0001);
    rd_hi; chk("R3 latch from read", bus_rdata, 32'h0000_0F00);

    cyc(1'b1, 1'b1, 1'b0, 32'hCAFE_0001, 4'h0);
    chk("R11 read dropped", bus_rdata, 32'h0000_0F00);
    rd_hi; chk("R11 write done", bus_rdata, 32'hCAFE_0001);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule